// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block gathers a set of hardware interrupt sources and a small number of software-raised sources into one request line for a processor. Each hardware source is recorded in a status word the moment its detector fires. The detector is chosen per source at build time: an active level or an active transition, with either polarity. A recorded bit stays set until software clears it. Software sees the recorded bits, decides which ones may reach the processor through an enable word, and turns the request output on with a global control bit.

Sources are ranked by index. Index 0 wins over every other source, and rank falls as the index grows. A vector word reports the winning eligible source, and reads as all ones when there is none. A threshold word supports nested handling. While a handler runs, software sets the threshold to the index of the source being served, and every source at that index or above is then held back from both the vector and the request. The software-raised sources sit in the top indices. Software sets them by writing the status word, but only while hardware capture is switched off. A build parameter selects whether the request output is a level or a single-cycle pulse.

Top module: `intc_core`

## Requirements
- R1: After reset the status word (address 0), enable word (address 2) and control word (address 5) read 0, the threshold word (address 6) reads the source count N, the vector word (address 4) reads all ones, and the request output is low.
- R2: A hardware source whose detector fires is recorded into its status bit whether or not it is enabled. Recording happens only while control bit 1 (hardware capture) is set. The bit then stays set after the input goes inactive, until it is acknowledged.
- R3: A source built for transitions is recorded only on an inactive-to-active change. Holding the input active after an acknowledge does not record it again. The polarity is chosen per source.
- R4: Writing the acknowledge word (address 3) clears every status bit written as 1 and leaves the other bits alone.
- R5: The pending word (address 1) reads the status bits ANDed with the enable bits.
- R6: The vector word (address 4) reads the lowest index among the pending bits that the threshold lets through. It reads all ones (32'hFFFF_FFFF) when no such bit exists.
- R7: A source whose index is greater than or equal to the threshold word is excluded from the vector and from the request.
- R8: The request rises one clock after the state first gives control bit 0 (request enable) set together with at least one eligible pending source. It stays low while control bit 0 is clear.
- R9: When built for pulse output, the request is high for exactly one clock each time the request condition of R8 turns from false to true.
- R10: A write of the status word (address 0) sets the status bits written as 1, but only for the software source indices NUM_HW to N-1. It has no effect while control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_HW | Hardware interrupt sources, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The bench builds two copies of the block with six hardware sources and two software sources, driven by the same stimulus. One copy has level output and the other has pulse output, so a single sequence checks both request shapes cycle by cycle. Sources 0 and 1 are built for transitions, and source 1 is active low. The remaining hardware sources are active-high levels. This setup reaches re-arming after an acknowledge, inverted polarity, and retention of a level source that has dropped. With eight sources the threshold word can be moved around a pending source, which shows the vector switching between an index and all ones.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_PEND = 3'd1,
        A_EN   = 3'd2,
        A_ACK  = 3'd3,
        A_VEC  = 3'd4,
        A_CTRL = 3'd5,
        A_LVL  = 3'd6
    } reg_addr_e;

    // control word: bit 1 hardware capture, bit 0 request enable
    typedef struct packed {
        logic hw_on;
        logic req_on;
    } ctrl_t;

endpackage

// File: rtl/intc_capture.sv
`timescale 1ns/1ps
module intc_capture #(
    parameter int                 NUM_HW     = 6,
    parameter logic [NUM_HW-1:0]  SENSE_EDGE = '0,
    parameter logic [NUM_HW-1:0]  ACT_HIGH   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] src_i,
    input  logic              arm_i,
    output logic [NUM_HW-1:0] hit_o
);

    typedef struct packed {
        logic [NUM_HW-1:0] prev;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_HW-1:0] act;
    logic [NUM_HW-1:0] raw;

    // normalise polarity so that 1 always means active
    assign act = ~(src_i ^ ACT_HIGH);

    for (genvar i = 0; i < NUM_HW; i++) begin : g_src
        if (SENSE_EDGE[i]) begin : g_edge
            assign raw[i] = act[i] & ~cap_q.prev[i];
        end else begin : g_level
            assign raw[i] = act[i];
        end
    end

    assign hit_o = raw & {NUM_HW{arm_i}};

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
module intc_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);

    // scan from the top so the lowest set index is the last one written
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/intc_reqgen.sv
`timescale 1ns/1ps
module intc_reqgen #(
    parameter bit PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
        logic prev;
    } rq_t;

    rq_t rq_d, rq_q;

    if (PULSE) begin : g_pulse
        always_comb begin
            rq_d      = rq_q;
            rq_d.irq  = cond_i & ~rq_q.prev;
            rq_d.prev = cond_i;
        end

        p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rq_q.irq |=> !rq_q.irq);
    end else begin : g_level
        always_comb begin
            rq_d      = rq_q;
            rq_d.irq  = cond_i;
            rq_d.prev = cond_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign irq_o = rq_q.irq;

endmodule

// File: rtl/intc_core.sv
`timescale 1ns/1ps
module intc_core
    import intc_pkg::*;
#(
    parameter int                NUM_HW     = 6,
    parameter int                NUM_SW     = 2,
    parameter int                DW         = 32,
    parameter logic [NUM_HW-1:0] SENSE_EDGE = '0,
    parameter logic [NUM_HW-1:0] ACT_HIGH   = '1,
    parameter bit                PULSE_OUT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] src_i,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_o
);

    localparam int N  = NUM_HW + NUM_SW;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int LW = $clog2(N + 1);

    function automatic logic [N-1:0] span_mask(int lo, int hi);
        logic [N-1:0] m;
        m = '0;
        for (int k = 0; k < N; k++) begin
            if (k >= lo && k < hi) m[k] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [N-1:0] SW_MASK = span_mask(NUM_HW, N);

    typedef struct packed {
        logic [N-1:0]  stat;
        logic [N-1:0]  en;
        ctrl_t         ctrl;
        logic [LW-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_HW-1:0] hit;
    logic [N-1:0]      hw_set;
    logic [N-1:0]      pend;
    logic [N-1:0]      lvl_gate;
    logic [N-1:0]      elig;
    logic              vld;
    logic [IW-1:0]     vidx;
    logic              cond;
    logic              unused_wr;

    assign unused_wr = ^wr_data;

    intc_capture #(
        .NUM_HW    (NUM_HW),
        .SENSE_EDGE(SENSE_EDGE),
        .ACT_HIGH  (ACT_HIGH)
    ) u_capture (
        .clk  (clk),
        .rst_n(rst_n),
        .src_i(src_i),
        .arm_i(st_q.ctrl.hw_on),
        .hit_o(hit)
    );

    always_comb begin
        hw_set             = '0;
        hw_set[NUM_HW-1:0] = hit;
    end

    // threshold: only indices strictly below it may compete
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign lvl_gate[i] = (LW'(i) < st_q.lvl);
    end

    assign pend = st_q.stat & st_q.en;
    assign elig = pend & lvl_gate;

    intc_prio #(
        .N (N),
        .IW(IW)
    ) u_prio (
        .req_i  (elig),
        .valid_o(vld),
        .idx_o  (vidx)
    );

    assign cond = st_q.ctrl.req_on & vld;

    intc_reqgen #(
        .PULSE(PULSE_OUT)
    ) u_reqgen (
        .clk   (clk),
        .rst_n (rst_n),
        .cond_i(cond),
        .irq_o (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_STAT: if (!st_q.ctrl.hw_on) st_d.stat = st_q.stat | (wr_data[N-1:0] & SW_MASK);
                A_EN:   st_d.en   = wr_data[N-1:0];
                A_ACK:  st_d.stat = st_q.stat & ~wr_data[N-1:0];
                A_CTRL: st_d.ctrl = ctrl_t'(wr_data[1:0]);
                A_LVL:  st_d.lvl  = wr_data[LW-1:0];
                default: ;
            endcase
        end
        // a fresh detection wins over an acknowledge in the same cycle
        st_d.stat = st_d.stat | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lvl  <= LW'(N);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_STAT: rd_data = DW'(st_q.stat);
            A_PEND: rd_data = DW'(pend);
            A_EN:   rd_data = DW'(st_q.en);
            A_VEC:  rd_data = vld ? DW'(vidx) : '1;
            A_CTRL: rd_data = DW'(st_q.ctrl);
            A_LVL:  rd_data = DW'(st_q.lvl);
            default: rd_data = '0;
        endcase
    end

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ACK && !st_q.ctrl.hw_on)
        |=> ((st_q.stat & $past(wr_data[N-1:0])) == '0));

    p_sw_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.hw_on |=> ((st_q.stat & SW_MASK & ~$past(st_q.stat)) == '0));

    p_retained_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_en) && $past(wr_addr) == A_ACK)
        |-> (($past(st_q.stat) & ~st_q.stat) == '0));

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(st_q.ctrl.req_on));

    p_vec_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (elig[vidx] && ((elig & ((N'(1) << vidx) - N'(1))) == '0)));

endmodule

// File: tb/test_intc_core.sv
`timescale 1ns/1ps
module test_intc_core;
    import intc_pkg::*;

    localparam int NUM_HW = 6;
    localparam int NUM_SW = 2;
    localparam int DW     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_HW-1:0] src = 6'b000010;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [2:0]        rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [DW-1:0]     rd_data_p;
    logic              irq_l;
    logic              irq_p;

    always #2 clk = ~clk;

    intc_core #(
        .NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .DW(DW),
        .SENSE_EDGE(6'b000011), .ACT_HIGH(6'b111101), .PULSE_OUT(1'b0)
    ) i_intc_core (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_l)
    );

    intc_core #(
        .NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .DW(DW),
        .SENSE_EDGE(6'b000011), .ACT_HIGH(6'b111101), .PULSE_OUT(1'b1)
    ) i_intc_core_pulse (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_p), .irq_o(irq_p)
    );

    typedef struct {
        int          kind;   // 0 register read, 1 level request, 2 pulse request
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    item_t cur;
    logic [31:0] got;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // monitor: compares the head item against the design, then retires it
    always begin
        wait (sb_q.size() > 0);
        cur = sb_q[0];
        case (cur.kind)
            0:       got = rd_data;
            1:       got = {31'b0, irq_l};
            default: got = {31'b0, irq_p};
        endcase
        n_checks++;
        if (got !== cur.exp) begin
            n_fail++;
            $display("FAIL %s: got=%h exp=%h", cur.tag, got, cur.exp);
        end
        void'(sb_q.pop_front());
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got=%0d cycles exp=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_item(int kind, logic [2:0] a, logic [31:0] e, string tag);
        item_t it;
        rd_addr = a;
        #0.1;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic irq_lvl(logic e, string tag);
        expect_item(1, 3'd0, {31'b0, e}, tag);
    endtask

    task automatic irq_pls(logic e, string tag);
        expect_item(2, 3'd0, {31'b0, e}, tag);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_EN,   32'h0, "R1 enable");
        rd(A_CTRL, 32'h0, "R1 control");
        rd(A_LVL,  32'd8, "R1 threshold");
        rd(A_VEC,  32'hFFFF_FFFF, "R1 vector");
        irq_lvl(1'b0, "R1 level request");
        irq_pls(1'b0, "R1 pulse request");

        // R2: no capture while hardware capture is off
        src[5] = 1'b1;
        step(2);
        rd(A_STAT, 32'h0, "R2 capture gated off");
        src[5] = 1'b0;

        wr(A_CTRL, 32'h2);
        src[2] = 1'b1;
        step(1);
        rd(A_STAT, 32'h04, "R2 recorded while disabled");
        rd(A_PEND, 32'h0, "R5 pending masked by enable");
        wr(A_EN, 32'hFF);
        rd(A_EN, 32'hFF, "R5 enable readback");
        rd(A_PEND, 32'h04, "R5 pending");
        rd(A_VEC, 32'd2, "R6 vector single");
        step(1);
        irq_lvl(1'b0, "R8 no request without enable");

        wr(A_CTRL, 32'h3);
        irq_lvl(1'b0, "R8 request one cycle late");
        step(1);
        irq_lvl(1'b1, "R8 request raised");
        irq_pls(1'b1, "R9 pulse high");
        step(1);
        irq_lvl(1'b1, "R8 request held");
        irq_pls(1'b0, "R9 pulse single cycle");

        src[2] = 1'b0;
        step(1);
        rd(A_STAT, 32'h04, "R2 retained after drop");
        wr(A_ACK, 32'h04);
        rd(A_STAT, 32'h0, "R4 acknowledge clears");
        step(1);
        irq_lvl(1'b0, "R8 request dropped");
        irq_pls(1'b0, "R9 pulse idle");

        // R3 edge source, rising
        src[0] = 1'b1;
        step(1);
        rd(A_STAT, 32'h01, "R3 rising edge recorded");
        rd(A_VEC, 32'd0, "R6 vector index 0");
        wr(A_ACK, 32'h01);
        step(1);
        rd(A_STAT, 32'h0, "R3 held input not re-recorded");

        // R3 edge source, active low; then priority
        src[1] = 1'b0;
        step(1);
        rd(A_STAT, 32'h02, "R3 falling edge recorded");
        src[3] = 1'b1;
        step(1);
        rd(A_STAT, 32'h0A, "R2 two sources");
        rd(A_VEC, 32'd1, "R6 lowest index wins");
        wr(A_ACK, 32'h02);
        rd(A_STAT, 32'h08, "R4 only written bit cleared");
        rd(A_VEC, 32'd3, "R6 next index");

        // R7 threshold
        wr(A_LVL, 32'd3);
        rd(A_LVL, 32'd3, "R7 threshold readback");
        rd(A_VEC, 32'hFFFF_FFFF, "R7 vector blocked");
        rd(A_PEND, 32'h08, "R5 pending ignores threshold");
        step(1);
        irq_lvl(1'b0, "R7 request blocked");
        wr(A_LVL, 32'd4);
        rd(A_VEC, 32'd3, "R7 threshold above index");
        step(1);
        irq_lvl(1'b1, "R7 request passes");
        irq_pls(1'b1, "R9 pulse on re-rise");
        wr(A_LVL, 32'd8);
        src[3] = 1'b0;
        step(1);
        wr(A_ACK, 32'h08);
        rd(A_STAT, 32'h0, "R4 cleared");
        step(1);
        irq_lvl(1'b0, "R8 request low");

        // R10 software sources
        wr(A_STAT, 32'hC1);
        rd(A_STAT, 32'h0, "R10 ignored while capture on");
        wr(A_CTRL, 32'h1);
        wr(A_STAT, 32'hFF);
        rd(A_STAT, 32'hC0, "R10 only software bits set");
        rd(A_VEC, 32'd6, "R6 software vector");
        irq_lvl(1'b0, "R8 request latency");
        step(1);
        irq_lvl(1'b1, "R10 software request");
        irq_pls(1'b1, "R9 pulse for software");
        src[4] = 1'b1;
        step(1);
        rd(A_STAT, 32'hC0, "R2 no capture with capture off");
        src[4] = 1'b0;
        wr(A_ACK, 32'h40);
        rd(A_VEC, 32'd7, "R6 last index");
        wr(A_ACK, 32'h80);
        rd(A_VEC, 32'hFFFF_FFFF, "R6 empty vector");
        step(1);
        irq_lvl(1'b0, "R8 request cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule